// File: doc/BRIEF.md
# Grouped Double-Buffered Compare Bank

This block holds the compare thresholds of a seven-channel timer. Each channel owns a buffer that software writes and a shadow copy that the hardware uses. The shadow is the only value ever compared with the count. A write lands in the buffer, and the buffer is copied into the shadow when that channel's chosen load event occurs. This lets software prepare new thresholds at any time without disturbing the period that is running.

The counter is outside this block. The block receives the count, a step strobe that marks a newly presented count value, the counting mode, and a length select. The length select truncates both the count and the shadows to 16, 12, 10 or 8 bits before any comparison. Channels can be tied into groups: pairs, triples, or one group holding all seven. Every shadow in a group then loads on the event of the group's leader channel, using the leader's load mode. The output is one match pulse per channel.

Top module: `shadow_compare_bank`

## Requirements
- R1: After reset every buffer, every shadow, every stored load mode and every match flag is 0.
- R2: A buffer write leaves the shadow unchanged until a load event fires. Match flags depend only on the shadow, never on the buffer.
- R3: Load mode 00 copies the buffer into the shadow on the same clock edge as the write. The mode written with a value governs the load decision on that same edge.
- R4: Load mode 01 loads the shadow on a step whose masked count equals 0.
- R5: Load mode 10 loads on a step at masked count 0 when the counting mode is up (01), continuous (10) or stopped (00). When the counting mode is up/down (11), it loads instead on a step where the masked count equals channel 0's masked shadow.
- R6: Load mode 11 loads on a step where the masked count equals channel 0's masked shadow, whatever the counting mode.
- R7: The length select masks the count and the shadows as follows: 00 keeps 16 bits, 01 keeps 12 bits, 10 keeps 10 bits and 11 keeps 8 bits. A count whose kept bits are all zero is a zero event.
- R8: Grouping 00 leaves every channel governed by its own load mode.
- R9: Grouping 01 ties channels 1 with 2, 3 with 4, and 5 with 6, each pair led by its lower channel. Channel 0 stays alone.
- R10: Grouping 10 ties channels 1 to 3, led by channel 1, and channels 4 to 6, led by channel 4. Channel 0 stays alone.
- R11: Grouping 11 ties all channels 0 to 6 into one group, led by channel 1.
- R12: When a leader's event fires, every member copies its own buffer, whether or not that buffer was written. A write on the same edge is included in the copy.
- R13: A channel's match flag is high for exactly the cycle after a step whose masked count equals that channel's masked shadow. The comparison uses the shadow held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_ch | input | 3 | Channel index written |
| wr_value | input | 16 | Threshold value written into the buffer |
| wr_lmode | input | 2 | Load mode stored with the write |
| grp_sel | input | 2 | Grouping select |
| len_sel | input | 2 | Count length select |
| cnt_mode | input | 2 | Counting mode: 00 stop, 01 up, 10 continuous, 11 up/down |
| cnt_step | input | 1 | A new count value is presented this cycle |
| count | input | 16 | Current counter value |
| shadow_flat | output | 112 | Shadow values, channel n in bits 16n+15:16n |
| match | output | 7 | Per-channel match pulses |

## Verification
The bench builds the bank with its default parameters: a 16-bit count and seven channels. With these values all four length selects can be tested, including counts whose upper bits must be masked off to create a zero event or a match. Every grouping pattern can also be reached. The vector table drives each load mode through the counting modes that change its behaviour. It then places a non-leader write under each grouping, so that the leader's mode, and not the member's own mode, decides when the shadow moves.

// File: rtl/cmpb_pkg.sv
package cmpb_pkg;

   localparam int unsigned BANK_CH  = 7;
   localparam int unsigned BANK_CHW = 3;

   typedef enum logic [1:0] {
      LD_ON_WRITE     = 2'b00,
      LD_AT_ZERO      = 2'b01,
      LD_ZERO_OR_TURN = 2'b10,
      LD_AT_PERIOD    = 2'b11
   } ld_mode_e;

   typedef enum logic [1:0] {
      RUN_HALT   = 2'b00,
      RUN_UP     = 2'b01,
      RUN_FREE   = 2'b10,
      RUN_UPDOWN = 2'b11
   } run_mode_e;

   typedef enum logic [1:0] {
      GRP_NONE    = 2'b00,
      GRP_PAIRS   = 2'b01,
      GRP_TRIPLES = 2'b10,
      GRP_ALL     = 2'b11
   } grp_e;

   // Channel whose load event governs channel ch under grouping g.
   function automatic logic [BANK_CHW-1:0] leader_of(grp_e g, logic [BANK_CHW-1:0] ch);
      logic [BANK_CHW-1:0] r;
      case (g)
         GRP_PAIRS:   r = (ch == '0) ? '0 : (ch[0] ? ch : ch - 3'd1);
         GRP_TRIPLES: r = (ch == '0) ? '0 : ((ch <= 3'd3) ? 3'd1 : 3'd4);
         GRP_ALL:     r = 3'd1;
         default:     r = ch;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cmpb_load_event.sv
module cmpb_load_event
   import cmpb_pkg::*;
(
   input  ld_mode_e  mode,
   input  run_mode_e run,
   input  logic      cnt_step,
   input  logic      at_zero,
   input  logic      at_turn,
   output logic      fire
);

   always_comb begin
      case (mode)
         LD_ON_WRITE:     fire = 1'b1;
         LD_AT_ZERO:      fire = cnt_step && at_zero;
         LD_ZERO_OR_TURN: fire = cnt_step && ((run == RUN_UPDOWN) ? at_turn : at_zero);
         default:         fire = cnt_step && at_turn;
      endcase
   end

endmodule

// File: rtl/cmpb_group_route.sv
module cmpb_group_route
   import cmpb_pkg::*;
#(
   parameter int unsigned NCH = BANK_CH
)(
   input  grp_e             grp,
   input  logic [NCH-1:0]   fire,
   output logic [NCH-1:0]   load
);

   for (genvar i = 0; i < NCH; i++) begin : g_route
      assign load[i] = fire[leader_of(grp, BANK_CHW'(i))];
   end

endmodule

// File: rtl/cmpb_channel.sv
module cmpb_channel
   import cmpb_pkg::*;
#(
   parameter int unsigned CW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_hit,
   input  logic [CW-1:0] wr_value,
   input  ld_mode_e      wr_mode,
   input  logic          load,
   input  logic [CW-1:0] cnt_m,
   input  logic [CW-1:0] len_mask,
   input  logic          cnt_step,
   output ld_mode_e      mode_nxt,
   output logic [CW-1:0] shadow_q,
   output logic          match_q
);

   logic [CW-1:0] buf_q;
   logic [CW-1:0] buf_nxt;
   ld_mode_e      mode_q;

   assign buf_nxt  = wr_hit ? wr_value : buf_q;
   assign mode_nxt = wr_hit ? wr_mode : mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q    <= '0;
         mode_q   <= LD_ON_WRITE;
         shadow_q <= '0;
         match_q  <= 1'b0;
      end else begin
         buf_q   <= buf_nxt;
         mode_q  <= mode_nxt;
         if (load) shadow_q <= buf_nxt;
         match_q <= cnt_step && (cnt_m == (shadow_q & len_mask));
      end
   end

   AST_SHADOW_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shadow_q)); // R2

   AST_BUF_HOLDS_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(buf_q)); // R2

   AST_MATCH_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_step |=> !match_q); // R13

endmodule

// File: rtl/shadow_compare_bank.sv
module shadow_compare_bank
   import cmpb_pkg::*;
#(
   parameter int unsigned CW  = 16,
   parameter int unsigned NCH = BANK_CH
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            wr_ch,
   input  logic [CW-1:0]         wr_value,
   input  logic [1:0]            wr_lmode,
   input  logic [1:0]            grp_sel,
   input  logic [1:0]            len_sel,
   input  logic [1:0]            cnt_mode,
   input  logic                  cnt_step,
   input  logic [CW-1:0]         count,
   output logic [NCH*CW-1:0]     shadow_flat,
   output logic [NCH-1:0]        match
);

   localparam logic [CW-1:0] MASK16 = CW'({16{1'b1}});
   localparam logic [CW-1:0] MASK12 = CW'({12{1'b1}});
   localparam logic [CW-1:0] MASK10 = CW'({10{1'b1}});
   localparam logic [CW-1:0] MASK8  = CW'({8{1'b1}});

   if (NCH != BANK_CH) begin : g_bad_nch
      $error("shadow_compare_bank: grouping needs exactly %0d channels", BANK_CH);
   end
   if (CW < 16) begin : g_bad_cw
      $error("shadow_compare_bank: count width must hold the 16-bit length");
   end

   logic [CW-1:0]  len_mask;
   logic [CW-1:0]  cnt_m;
   logic           at_zero;
   logic           at_turn;
   logic [NCH-1:0] fire;
   logic [NCH-1:0] load;
   logic [CW-1:0]  shadow [NCH];
   ld_mode_e       mode_nxt [NCH];
   grp_e           grp;

   always_comb begin
      case (len_sel)
         2'b01:   len_mask = MASK12;
         2'b10:   len_mask = MASK10;
         2'b11:   len_mask = MASK8;
         default: len_mask = MASK16;
      endcase
   end

   assign grp     = grp_e'(grp_sel);
   assign cnt_m   = count & len_mask;
   assign at_zero = (cnt_m == '0);
   assign at_turn = (cnt_m == (shadow[0] & len_mask));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      cmpb_channel #(.CW(CW)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (wr_en && (wr_ch == 3'(i))),
         .wr_value (wr_value),
         .wr_mode  (ld_mode_e'(wr_lmode)),
         .load     (load[i]),
         .cnt_m    (cnt_m),
         .len_mask (len_mask),
         .cnt_step (cnt_step),
         .mode_nxt (mode_nxt[i]),
         .shadow_q (shadow[i]),
         .match_q  (match[i])
      );

      cmpb_load_event u_evt (
         .mode     (mode_nxt[i]),
         .run      (run_mode_e'(cnt_mode)),
         .cnt_step (cnt_step),
         .at_zero  (at_zero),
         .at_turn  (at_turn),
         .fire     (fire[i])
      );

      assign shadow_flat[i*CW +: CW] = shadow[i];
   end

   cmpb_group_route #(.NCH(NCH)) u_route (
      .grp  (grp),
      .fire (fire),
      .load (load)
   );

   AST_PAIRS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel == 2'b01) |-> (load[1] == load[2] && load[3] == load[4] && load[5] == load[6])); // R9

   AST_TRIPLES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel == 2'b10) |-> (load[1] == load[2] && load[2] == load[3] &&
                              load[4] == load[5] && load[5] == load[6])); // R10

   AST_ALL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel == 2'b11) |-> (load == '0 || load == '1)); // R11

   AST_PAIR_LEADER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel == 2'b01 && load[6] && !cnt_step) |-> (mode_nxt[5] == LD_ON_WRITE)); // R9

endmodule

// File: tb/tb_shadow_compare_bank.sv
module tb_shadow_compare_bank;

   localparam int CW  = 16;
   localparam int NCH = 7;
   localparam int NV  = 29;

   typedef struct packed {
      logic        we;
      logic [2:0]  sel;
      logic [15:0] dat;
      logic [1:0]  lm;
      logic [1:0]  grp;
      logic [1:0]  len;
      logic [1:0]  cm;
      logic        stp;
      logic [15:0] cnt;
      logic [2:0]  ch;
      logic [15:0] lat;
      logic [6:0]  mt;
      logic [3:0]  tag;
   } vec_t;

   // fields: we sel dat lm grp len cm stp cnt | check ch, shadow, match, requirement
   localparam vec_t VEC [NV] = '{
      '{1'b1,3'd2,16'h0123,2'd0,2'd0,2'd0,2'd0,1'b0,16'h0000,3'd2,16'h0123,7'b0000000,4'd3},  // R3
      '{1'b1,3'd3,16'h0050,2'd1,2'd0,2'd0,2'd0,1'b0,16'h0000,3'd3,16'h0000,7'b0000000,4'd2},  // R2
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd1,1'b1,16'h0007,3'd3,16'h0000,7'b0000000,4'd4},  // R4
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd1,1'b1,16'h0000,3'd3,16'h0050,7'b1111011,4'd4},  // R4
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd1,1'b1,16'h0050,3'd3,16'h0050,7'b0001000,4'd13}, // R13
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd1,2'd1,1'b1,16'h1123,3'd2,16'h0123,7'b0000100,4'd7},  // R7
      '{1'b1,3'd3,16'h0AAA,2'd1,2'd0,2'd1,2'd1,1'b0,16'h0000,3'd3,16'h0050,7'b0000000,4'd2},  // R2
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd1,2'd1,1'b1,16'h3000,3'd3,16'h0AAA,7'b1110011,4'd7},  // R7
      '{1'b1,3'd0,16'h0040,2'd0,2'd0,2'd0,2'd1,1'b0,16'h0000,3'd0,16'h0040,7'b0000000,4'd3},  // R3
      '{1'b1,3'd4,16'h0200,2'd2,2'd0,2'd0,2'd1,1'b0,16'h0000,3'd4,16'h0000,7'b0000000,4'd2},  // R2
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd3,1'b1,16'h0000,3'd4,16'h0000,7'b1110010,4'd5},  // R5
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd3,1'b1,16'h0040,3'd4,16'h0200,7'b0000001,4'd5},  // R5
      '{1'b1,3'd4,16'h0300,2'd2,2'd0,2'd0,2'd1,1'b0,16'h0000,3'd4,16'h0200,7'b0000000,4'd2},  // R2
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd1,1'b1,16'h0040,3'd4,16'h0200,7'b0000001,4'd5},  // R5
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd2,1'b1,16'h0000,3'd4,16'h0300,7'b1100010,4'd5},  // R5
      '{1'b1,3'd5,16'h0077,2'd3,2'd0,2'd0,2'd1,1'b0,16'h0000,3'd5,16'h0000,7'b0000000,4'd2},  // R2
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd1,1'b1,16'h0000,3'd5,16'h0000,7'b1100010,4'd6},  // R6
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd2,1'b1,16'h0040,3'd5,16'h0077,7'b0000001,4'd6},  // R6
      '{1'b1,3'd6,16'h0066,2'd0,2'd1,2'd0,2'd1,1'b0,16'h0000,3'd6,16'h0000,7'b0000000,4'd9},  // R9
      '{1'b0,3'd0,16'h0000,2'd0,2'd1,2'd0,2'd1,1'b1,16'h0040,3'd6,16'h0066,7'b0000001,4'd9},  // R9
      '{1'b1,3'd5,16'h0555,2'd0,2'd2,2'd0,2'd1,1'b0,16'h0000,3'd5,16'h0077,7'b0000000,4'd10}, // R10
      '{1'b0,3'd0,16'h0000,2'd0,2'd2,2'd0,2'd2,1'b1,16'h0000,3'd5,16'h0555,7'b0000010,4'd10}, // R10
      '{1'b1,3'd1,16'h0011,2'd1,2'd0,2'd0,2'd1,1'b0,16'h0000,3'd1,16'h0000,7'b0000000,4'd8},  // R8
      '{1'b1,3'd0,16'h0099,2'd0,2'd3,2'd0,2'd1,1'b0,16'h0000,3'd0,16'h0040,7'b0000000,4'd11}, // R11
      '{1'b0,3'd0,16'h0000,2'd0,2'd3,2'd0,2'd1,1'b1,16'h0000,3'd0,16'h0099,7'b0000010,4'd12}, // R11 R12
      '{1'b1,3'd2,16'h0222,2'd1,2'd0,2'd0,2'd1,1'b0,16'h0000,3'd2,16'h0123,7'b0000000,4'd8},  // R8
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd0,2'd1,1'b1,16'h0000,3'd2,16'h0222,7'b0000000,4'd12}, // R12
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd3,2'd1,1'b1,16'h3F11,3'd1,16'h0011,7'b0000010,4'd7},  // R7
      '{1'b0,3'd0,16'h0000,2'd0,2'd0,2'd3,2'd1,1'b1,16'h01AA,3'd3,16'h0AAA,7'b0001000,4'd7}   // R7
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_ch = '0;
   logic [CW-1:0]     wr_value = '0;
   logic [1:0]        wr_lmode = '0;
   logic [1:0]        grp_sel = '0;
   logic [1:0]        len_sel = '0;
   logic [1:0]        cnt_mode = '0;
   logic              cnt_step = 1'b0;
   logic [CW-1:0]     count = '0;
   logic [NCH*CW-1:0] shadow_flat;
   logic [NCH-1:0]    match;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   shadow_compare_bank #(.CW(CW), .NCH(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_value(wr_value),
      .wr_lmode(wr_lmode), .grp_sel(grp_sel), .len_sel(len_sel), .cnt_mode(cnt_mode),
      .cnt_step(cnt_step), .count(count), .shadow_flat(shadow_flat), .match(match)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      for (int c = 0; c < NCH; c++) chk($sformatf("R1 reset shadow ch%0d", c), shadow_flat[c*CW +: CW], 16'h0000);
      chk("R1 reset match", {9'd0, match}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         wr_en    = VEC[k].we;
         wr_ch    = VEC[k].sel;
         wr_value = VEC[k].dat;
         wr_lmode = VEC[k].lm;
         grp_sel  = VEC[k].grp;
         len_sel  = VEC[k].len;
         cnt_mode = VEC[k].cm;
         cnt_step = VEC[k].stp;
         count    = VEC[k].cnt;
         @(posedge clk);
         #1;
         chk($sformatf("R%0d vec%0d shadow ch%0d", VEC[k].tag, k, VEC[k].ch),
             shadow_flat[VEC[k].ch*CW +: CW], VEC[k].lat);
         chk($sformatf("R%0d vec%0d match", VEC[k].tag, k), {9'd0, match}, {9'd0, VEC[k].mt});
      end

      // R1: reset in mid-run clears shadows and flags
      @(negedge clk);
      wr_en = 1'b0; cnt_step = 1'b1; count = 16'h0000; grp_sel = 2'b00; len_sel = 2'b00;
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 mid-run reset shadow ch3", shadow_flat[3*CW +: CW], 16'h0000);
      chk("R1 mid-run reset match", {9'd0, match}, 16'h0000);
      // R1: buffers and modes were cleared too: mode 00 shadows follow buffers of 0
      @(negedge clk);
      rst_n = 1'b1;
      cnt_step = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 buffer cleared ch3", shadow_flat[3*CW +: CW], 16'h0000);
      chk("R1 buffer cleared ch5", shadow_flat[5*CW +: CW], 16'h0000);
      // R3: after reset the stored mode is 00, so a write is visible at once
      @(negedge clk);
      wr_en = 1'b1; wr_ch = 3'd6; wr_value = 16'h0F0F; wr_lmode = 2'b00;
      @(posedge clk);
      #1;
      chk("R3 immediate after reset ch6", shadow_flat[6*CW +: CW], 16'h0F0F);
      @(negedge clk);
      wr_en = 1'b0;
      finish_run();
   end

endmodule